// File: doc/BRIEF.md
# Multi-Dimensional Transfer Address Generator

This block walks one data-move record of up to four dimensions and turns it into a stream of row bursts. A row is a contiguous run of bytes whose length is the innermost count. Up to three outer loops step the row address by signed byte strides. The record's flag word selects the number of dimensions, how the walk is paced by external triggers, and when a progress event is raised. When the walk ends, the block returns a 32-bit completion word.

The host loads a record with a one-cycle `start` pulse while the block is idle. It then reads one `burst_addr`/`burst_len` pair for each cycle that `burst_valid` is high. If a trigger source is configured, each pulse on the selected source releases rows up to the next step of a chosen loop level, or releases the rest of the record. An `abort` pulse ends the walk early. The block moves no data and drives no bus protocol.

Top module: `tr_addr_gen`

## Requirements
- R1: After reset `busy`, `burst_valid`, `event_o` and `done` are low. A `start` pulse is accepted only while `busy` is low. A `start` pulse while busy has no effect on the running record's bursts or completion.
- R2: Flag bits 3:0 give the record kind. Values 0, 1, 2 and 3 walk 1, 2, 3 and 4 dimensions, and outer counts above the record's dimension count are treated as one. Any kind above 3 issues no burst and completes with status 4 (unsupported), info 0.
- R3: A supported record whose innermost count is zero issues no burst and completes with status 3 (submission error), info 0. The kind check takes precedence when both apply. `burst_len` is never zero while `burst_valid` is high.
- R4: Every burst length equals the innermost count. Row (k1,k2,k3) has the address start + k1·dim1 + k2·dim2 + k3·dim3, with strides sign-extended and the sum wrapping at the address width. k1 varies fastest and k3 slowest.
- R5: When both trigger selects (flag bits 9:8 and 13:12) are 0, one burst is issued every cycle, starting in the cycle after `start` is sampled.
- R6: Trigger select codes are 1 for `trig_glb0`, 2 for `trig_glb1` and 3 for `trig_local`. When a select is nonzero, no burst is issued until a pulse arrives on a selected input while no release is pending. Pulses on unselected inputs have no effect. If both triggers fire in the same cycle, trigger 0 wins.
- R7: The trigger type fields are flag bits 11:10 for trigger 0 and 15:14 for trigger 1. Codes 0, 1 and 2 release rows until outer count 1, 2 or 3 steps once. Code 3 releases the rest of the record. A code that names a loop level the record does not have releases the rest of the record.
- R8: Flag bits 7:6 set the event granularity. Code 0 pulses `event_o` in the `done` cycle of a record that completed normally. Codes 1 to 3 pulse `event_o` with every burst that steps outer count 1, 2 or 3. If that level does not exist for the record kind, the pulse comes with the last burst only.
- R9: `done` is a one-cycle pulse. It comes one cycle after the last burst, after `start` for a rejected record, or after `abort`. `resp` carries the status in bits 3:0 (0 complete), info in bits 7:4, the command id from flag bits 23:16 in bits 23:16, and zero in bits 15:8 and 31:24.
- R10: `abort` while a record is walking suppresses the burst of that cycle, and `done` follows in the next cycle with status 2. `abort` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load the record on the `rec_*` inputs |
| rec_flags | input | 32 | Record flag word |
| rec_icnt0 | input | CNT_W | Bytes per row |
| rec_icnt1 | input | CNT_W | Outer count 1 |
| rec_icnt2 | input | CNT_W | Outer count 2 |
| rec_icnt3 | input | CNT_W | Outer count 3 |
| rec_addr | input | ADDR_W | Start address |
| rec_dim1 | input | STRIDE_W | Signed stride of loop 1 |
| rec_dim2 | input | STRIDE_W | Signed stride of loop 2 |
| rec_dim3 | input | STRIDE_W | Signed stride of loop 3 |
| trig_glb0 | input | 1 | Global trigger source 0 |
| trig_glb1 | input | 1 | Global trigger source 1 |
| trig_local | input | 1 | Local event trigger source |
| abort | input | 1 | Stop the running record |
| busy | output | 1 | A record is loaded |
| burst_valid | output | 1 | A row burst is issued this cycle |
| burst_addr | output | ADDR_W | Row start address |
| burst_len | output | CNT_W | Row length in bytes |
| event_o | output | 1 | Progress event pulse |
| done | output | 1 | Completion pulse |
| resp | output | 32 | Completion word |

## Verification
The checker assumes that `abort`, `start` and the trigger inputs are synchronous one-cycle pulses. It also assumes that the `rec_*` inputs are stable in the cycle `start` is sampled. It does not check outer counts of zero, which are outside the defined behaviour. The directed tasks drive every pulse for exactly one cycle from the falling edge and always load outer counts of at least one. They also hold the record inputs steady across the start cycle.

// File: rtl/tag_pkg.sv
package tag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } walk_st_e;

    // release granted by a trigger
    typedef enum logic [2:0] {
        LV_NONE = 3'd0,
        LV_1    = 3'd1,
        LV_2    = 3'd2,
        LV_3    = 3'd3,
        LV_ALL  = 3'd4
    } rel_lvl_e;

    localparam logic [3:0] CODE_OK     = 4'd0;
    localparam logic [3:0] CODE_ABORT  = 4'd2;
    localparam logic [3:0] CODE_SUBMIT = 4'd3;
    localparam logic [3:0] CODE_UNSUP  = 4'd4;

    localparam logic [3:0] MAX_KIND = 4'd3;

    // Trigger type code to release level, with fallback to whole record
    function automatic rel_lvl_e type_to_lvl(input logic [1:0] typ,
                                             input logic [1:0] kind);
        rel_lvl_e r;
        if (typ == 2'd3 || typ >= kind) begin
            r = LV_ALL;
        end else begin
            case (typ)
                2'd0:    r = LV_1;
                2'd1:    r = LV_2;
                default: r = LV_3;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/tag_rec_check.sv
module tag_rec_check
    import tag_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [3:0]       kind_raw,
    input  logic [CNT_W-1:0] icnt0,
    output logic             ok,
    output logic [3:0]       code
);
    always_comb begin
        if (kind_raw > MAX_KIND) begin
            ok   = 1'b0;
            code = CODE_UNSUP;
        end else if (icnt0 == '0) begin
            ok   = 1'b0;
            code = CODE_SUBMIT;
        end else begin
            ok   = 1'b1;
            code = CODE_OK;
        end
    end
endmodule

// File: rtl/tag_trig_sel.sv
module tag_trig_sel
    import tag_pkg::*;
(
    input  logic [1:0] sel0,
    input  logic [1:0] typ0,
    input  logic [1:0] sel1,
    input  logic [1:0] typ1,
    input  logic [1:0] kind,
    input  logic       glb0,
    input  logic       glb1,
    input  logic       loc,
    output logic       free_run,
    output logic       hit,
    output rel_lvl_e   lvl
);
    logic [1:0] sel_v [2];
    logic [1:0] typ_v [2];
    logic [1:0] fired;

    assign sel_v[0] = sel0;
    assign sel_v[1] = sel1;
    assign typ_v[0] = typ0;
    assign typ_v[1] = typ1;

    for (genvar g = 0; g < 2; g++) begin : g_src
        always_comb begin
            case (sel_v[g])
                2'd1:    fired[g] = glb0;
                2'd2:    fired[g] = glb1;
                2'd3:    fired[g] = loc;
                default: fired[g] = 1'b0;
            endcase
        end
    end

    assign free_run = (sel0 == 2'd0) && (sel1 == 2'd0);
    assign hit      = |fired;

    always_comb begin
        if (fired[0]) lvl = type_to_lvl(typ_v[0], kind);
        else if (fired[1]) lvl = type_to_lvl(typ_v[1], kind);
        else lvl = LV_NONE;
    end
endmodule

// File: rtl/tag_step.sv
module tag_step #(
    parameter int CNT_W    = 16,
    parameter int ADDR_W   = 40,
    parameter int STRIDE_W = 32
) (
    input  logic [CNT_W-1:0]    n1,
    input  logic [CNT_W-1:0]    n2,
    input  logic [CNT_W-1:0]    n3,
    input  logic [CNT_W-1:0]    c1,
    input  logic [CNT_W-1:0]    c2,
    input  logic [CNT_W-1:0]    c3,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [ADDR_W-1:0]   b2,
    input  logic [ADDR_W-1:0]   b3,
    input  logic [STRIDE_W-1:0] d1,
    input  logic [STRIDE_W-1:0] d2,
    input  logic [STRIDE_W-1:0] d3,
    output logic [CNT_W-1:0]    c1_n,
    output logic [CNT_W-1:0]    c2_n,
    output logic [CNT_W-1:0]    c3_n,
    output logic [ADDR_W-1:0]   addr_n,
    output logic [ADDR_W-1:0]   b2_n,
    output logic [ADDR_W-1:0]   b3_n,
    output logic [2:0]          dec,
    output logic                last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic w1, w2, w3;
    logic [ADDR_W-1:0] s1, s2, s3;

    assign s1 = ADDR_W'($signed(d1));
    assign s2 = ADDR_W'($signed(d2));
    assign s3 = ADDR_W'($signed(d3));

    assign w1 = (c1 + ONE) == n1;
    assign w2 = (c2 + ONE) == n2;
    assign w3 = (c3 + ONE) == n3;

    assign dec  = {w1 & w2, w1, 1'b1};
    assign last = w1 & w2 & w3;

    always_comb begin
        c1_n   = c1;
        c2_n   = c2;
        c3_n   = c3;
        addr_n = addr;
        b2_n   = b2;
        b3_n   = b3;
        if (!w1) begin
            c1_n   = c1 + ONE;
            addr_n = addr + s1;
        end else if (!w2) begin
            c1_n   = '0;
            c2_n   = c2 + ONE;
            b2_n   = b2 + s2;
            addr_n = b2 + s2;
        end else if (!w3) begin
            c1_n   = '0;
            c2_n   = '0;
            c3_n   = c3 + ONE;
            b3_n   = b3 + s3;
            b2_n   = b3 + s3;
            addr_n = b3 + s3;
        end
    end
endmodule

// File: rtl/tag_evt.sv
module tag_evt (
    input  logic [1:0] evsz,
    input  logic [1:0] kind,
    input  logic       row_fire,
    input  logic [2:0] dec,
    input  logic       last,
    input  logic       fin_ok,
    output logic       evt
);
    logic lvl_exists;
    logic row_hit;

    assign lvl_exists = evsz <= kind;

    always_comb begin
        row_hit = 1'b0;
        if (evsz != 2'd0) begin
            row_hit = lvl_exists ? dec[evsz - 2'd1] : last;
        end
    end

    assign evt = (row_fire && row_hit) || (fin_ok && evsz == 2'd0);
endmodule

// File: rtl/tr_addr_gen.sv
module tr_addr_gen
    import tag_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int ADDR_W   = 40,
    parameter int STRIDE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [31:0]         rec_flags,
    input  logic [CNT_W-1:0]    rec_icnt0,
    input  logic [CNT_W-1:0]    rec_icnt1,
    input  logic [CNT_W-1:0]    rec_icnt2,
    input  logic [CNT_W-1:0]    rec_icnt3,
    input  logic [ADDR_W-1:0]   rec_addr,
    input  logic [STRIDE_W-1:0] rec_dim1,
    input  logic [STRIDE_W-1:0] rec_dim2,
    input  logic [STRIDE_W-1:0] rec_dim3,
    input  logic                trig_glb0,
    input  logic                trig_glb1,
    input  logic                trig_local,
    input  logic                abort,
    output logic                busy,
    output logic                burst_valid,
    output logic [ADDR_W-1:0]   burst_addr,
    output logic [CNT_W-1:0]    burst_len,
    output logic                event_o,
    output logic                done,
    output logic [31:0]         resp
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        walk_st_e            st;
        logic [1:0]          kind;
        logic [1:0]          evsz;
        logic [1:0]          sel0;
        logic [1:0]          typ0;
        logic [1:0]          sel1;
        logic [1:0]          typ1;
        logic [7:0]          cmd;
        logic [3:0]          code;
        rel_lvl_e            permit;
        logic [CNT_W-1:0]    len;
        logic [CNT_W-1:0]    n1;
        logic [CNT_W-1:0]    n2;
        logic [CNT_W-1:0]    n3;
        logic [CNT_W-1:0]    c1;
        logic [CNT_W-1:0]    c2;
        logic [CNT_W-1:0]    c3;
        logic [ADDR_W-1:0]   addr;
        logic [ADDR_W-1:0]   b2;
        logic [ADDR_W-1:0]   b3;
        logic [STRIDE_W-1:0] d1;
        logic [STRIDE_W-1:0] d2;
        logic [STRIDE_W-1:0] d3;
    } walk_t;

    walk_t w_q, w_d;

    logic       unused_flag_bits;
    logic       rec_ok;
    logic [3:0] rec_code;
    logic       free_run, trig_hit;
    rel_lvl_e   trig_lvl;
    logic [CNT_W-1:0]  c1_n, c2_n, c3_n;
    logic [ADDR_W-1:0] addr_n, b2_n, b3_n;
    logic [2:0] dec;
    logic       last_row;
    logic       row_fire;
    logic       consumed;

    assign unused_flag_bits = ^{rec_flags[31:24], rec_flags[5:4]};

    tag_rec_check #(.CNT_W(CNT_W)) rec_check_i (
        .kind_raw (rec_flags[3:0]),
        .icnt0    (rec_icnt0),
        .ok       (rec_ok),
        .code     (rec_code)
    );

    tag_trig_sel trig_sel_i (
        .sel0     (w_q.sel0),
        .typ0     (w_q.typ0),
        .sel1     (w_q.sel1),
        .typ1     (w_q.typ1),
        .kind     (w_q.kind),
        .glb0     (trig_glb0),
        .glb1     (trig_glb1),
        .loc      (trig_local),
        .free_run (free_run),
        .hit      (trig_hit),
        .lvl      (trig_lvl)
    );

    tag_step #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) step_i (
        .n1     (w_q.n1),
        .n2     (w_q.n2),
        .n3     (w_q.n3),
        .c1     (w_q.c1),
        .c2     (w_q.c2),
        .c3     (w_q.c3),
        .addr   (w_q.addr),
        .b2     (w_q.b2),
        .b3     (w_q.b3),
        .d1     (w_q.d1),
        .d2     (w_q.d2),
        .d3     (w_q.d3),
        .c1_n   (c1_n),
        .c2_n   (c2_n),
        .c3_n   (c3_n),
        .addr_n (addr_n),
        .b2_n   (b2_n),
        .b3_n   (b3_n),
        .dec    (dec),
        .last   (last_row)
    );

    assign row_fire = (w_q.st == ST_RUN) && !abort &&
                      (free_run || w_q.permit != LV_NONE);

    always_comb begin
        case (w_q.permit)
            LV_1:    consumed = dec[0];
            LV_2:    consumed = dec[1];
            LV_3:    consumed = dec[2];
            default: consumed = 1'b0;
        endcase
    end

    tag_evt evt_i (
        .evsz     (w_q.evsz),
        .kind     (w_q.kind),
        .row_fire (row_fire),
        .dec      (dec),
        .last     (last_row),
        .fin_ok   ((w_q.st == ST_FIN) && (w_q.code == CODE_OK)),
        .evt      (event_o)
    );

    always_comb begin
        w_d = w_q;
        case (w_q.st)
            ST_IDLE: begin
                if (start) begin
                    w_d.kind   = rec_flags[1:0];
                    w_d.evsz   = rec_flags[7:6];
                    w_d.sel0   = rec_flags[9:8];
                    w_d.typ0   = rec_flags[11:10];
                    w_d.sel1   = rec_flags[13:12];
                    w_d.typ1   = rec_flags[15:14];
                    w_d.cmd    = rec_flags[23:16];
                    w_d.len    = rec_icnt0;
                    w_d.n1     = (rec_flags[1:0] >= 2'd1) ? rec_icnt1 : ONE;
                    w_d.n2     = (rec_flags[1:0] >= 2'd2) ? rec_icnt2 : ONE;
                    w_d.n3     = (rec_flags[1:0] == 2'd3) ? rec_icnt3 : ONE;
                    w_d.c1     = '0;
                    w_d.c2     = '0;
                    w_d.c3     = '0;
                    w_d.addr   = rec_addr;
                    w_d.b2     = rec_addr;
                    w_d.b3     = rec_addr;
                    w_d.d1     = rec_dim1;
                    w_d.d2     = rec_dim2;
                    w_d.d3     = rec_dim3;
                    w_d.permit = LV_NONE;
                    w_d.code   = rec_code;
                    w_d.st     = rec_ok ? ST_RUN : ST_FIN;
                end
            end
            ST_RUN: begin
                if (abort) begin
                    w_d.code = CODE_ABORT;
                    w_d.st   = ST_FIN;
                end else begin
                    if (row_fire) begin
                        w_d.c1   = c1_n;
                        w_d.c2   = c2_n;
                        w_d.c3   = c3_n;
                        w_d.addr = addr_n;
                        w_d.b2   = b2_n;
                        w_d.b3   = b3_n;
                        if (consumed) w_d.permit = LV_NONE;
                        if (last_row) w_d.st = ST_FIN;
                    end
                    if (!free_run && w_q.permit == LV_NONE && trig_hit) begin
                        w_d.permit = trig_lvl;
                    end
                end
            end
            ST_FIN: begin
                w_d.st     = ST_IDLE;
                w_d.permit = LV_NONE;
            end
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign busy        = w_q.st != ST_IDLE;
    assign burst_valid = row_fire;
    assign burst_addr  = w_q.addr;
    assign burst_len   = w_q.len;
    assign done        = w_q.st == ST_FIN;
    assign resp        = {8'h00, w_q.cmd, 8'h00, 4'h0, w_q.code};

endmodule

// File: rtl/tag_chk.sv
module tag_chk #(
    parameter int CNT_W    = 16,
    parameter int ADDR_W   = 40,
    parameter int STRIDE_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [31:0]      rec_flags,
    input logic [CNT_W-1:0] rec_icnt0,
    input logic             abort,
    input logic             busy,
    input logic             burst_valid,
    input logic [CNT_W-1:0] burst_len,
    input logic             event_o,
    input logic             done,
    input logic [31:0]      resp
);
    // R1
    burst_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> busy);

    // R8
    event_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> busy);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    resp_zero_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (resp[15:8] == 8'h00 && resp[31:24] == 8'h00 && resp[7:4] == 4'h0));

    // R3
    zero_row_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && rec_icnt0 == '0 && rec_flags[3:0] <= 4'd3)
        |=> (done && resp[3:0] == 4'd3));

    // R2
    kind_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && rec_flags[3:0] > 4'd3) |=> (done && resp[3:0] == 4'd4));

    // R3
    no_empty_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> burst_len != '0);

    // R10
    abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && busy && !done) |=> (done && resp[3:0] == 4'd2));

    // R10
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !burst_valid);

endmodule

bind tr_addr_gen tag_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) chk_i (.*);

// File: tb/tr_addr_gen_tb_top.sv
module tr_addr_gen_tb_top;
    localparam int CNT_W    = 16;
    localparam int ADDR_W   = 40;
    localparam int STRIDE_W = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [31:0]         rec_flags = '0;
    logic [CNT_W-1:0]    rec_icnt0 = '0, rec_icnt1 = '0, rec_icnt2 = '0, rec_icnt3 = '0;
    logic [ADDR_W-1:0]   rec_addr = '0;
    logic [STRIDE_W-1:0] rec_dim1 = '0, rec_dim2 = '0, rec_dim3 = '0;
    logic                trig_glb0 = 1'b0, trig_glb1 = 1'b0, trig_local = 1'b0;
    logic                abort = 1'b0;
    logic                busy, burst_valid, event_o, done;
    logic [ADDR_W-1:0]   burst_addr;
    logic [CNT_W-1:0]    burst_len;
    logic [31:0]         resp;

    always #5 clk = ~clk;

    tr_addr_gen #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) dut_i (.*);

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [ADDR_W-1:0] b_addr [64];
    logic [CNT_W-1:0]  b_len  [64];
    int nb, ne, ev_done, nd, first_cyc, last_cyc, done_cyc, start_cyc;
    int ev_at [16];
    logic [31:0] last_resp;
    logic [ADDR_W-1:0] exp_a [64];
    int n_exp;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (burst_valid) begin
                if (nb < 64) begin
                    b_addr[nb] = burst_addr;
                    b_len[nb]  = burst_len;
                end
                if (nb == 0) first_cyc = cyc;
                last_cyc = cyc;
                nb++;
            end
            if (event_o) begin
                if (done) ev_done++;
                else begin
                    if (ne < 16) ev_at[ne] = nb;
                    ne++;
                end
            end
            if (done) begin
                nd++;
                last_resp = resp;
                done_cyc = cyc;
            end
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        nb = 0; ne = 0; ev_done = 0; nd = 0; last_resp = '0;
        first_cyc = -1; last_cyc = -1; done_cyc = -1;
    endtask

    function automatic logic [31:0] mk_flags(input int kind, input int evsz,
        input int s0, input int y0, input int s1, input int y1, input int cmd);
        return {8'h00, 8'(cmd), 2'(y1), 2'(s1), 2'(y0), 2'(s0), 2'(evsz), 2'b00, 4'(kind)};
    endfunction

    function automatic void build_exp(input longint base, input int n1, input int n2,
        input int n3, input longint d1, input longint d2, input longint d3);
        n_exp = 0;
        for (int k3 = 0; k3 < n3; k3++)
            for (int k2 = 0; k2 < n2; k2++)
                for (int k1 = 0; k1 < n1; k1++) begin
                    exp_a[n_exp] = ADDR_W'(base + k3 * d3 + k2 * d2 + k1 * d1);
                    n_exp++;
                end
    endfunction

    task automatic launch(input logic [31:0] f, input int n0, input int n1, input int n2,
        input int n3, input longint base, input longint d1, input longint d2, input longint d3);
        @(negedge clk);
        clear_mon();
        rec_flags = f;
        rec_icnt0 = CNT_W'(n0); rec_icnt1 = CNT_W'(n1);
        rec_icnt2 = CNT_W'(n2); rec_icnt3 = CNT_W'(n3);
        rec_addr  = ADDR_W'(base);
        rec_dim1  = STRIDE_W'(d1); rec_dim2 = STRIDE_W'(d2); rec_dim3 = STRIDE_W'(d3);
        start = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            if (nd > 0) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: trig_glb0 = 1'b1;
            1: trig_glb1 = 1'b1;
            2: trig_local = 1'b1;
            default: abort = 1'b1;
        endcase
        @(negedge clk);
        trig_glb0 = 1'b0; trig_glb1 = 1'b0; trig_local = 1'b0; abort = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_rows(input string req);
        chk({req, " burst count"}, nb, n_exp);
        for (int i = 0; i < n_exp && i < 64; i++) begin
            chk({req, " burst addr"}, b_addr[i], exp_a[i]);
        end
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", busy, 0);
        chk("R1 burst_valid after reset", burst_valid, 0);
        chk("R1 event after reset", event_o, 0);
        chk("R1 done after reset", done, 0);
    endtask

    task automatic t_free_3d();
        launch(mk_flags(2, 0, 0, 0, 0, 0, 8'h5A), 8, 3, 2, 7,
               40'h10_0000_1000, 64'h100, -64'h40, 64'h5555);
        wait_done();
        build_exp(40'h10_0000_1000, 3, 2, 1, 64'h100, -64'h40, 0);
        check_rows("R4 R2 3-D walk");
        chk("R4 burst length", b_len[5], 8);
        chk("R5 first burst cycle", first_cyc, start_cyc + 1);
        chk("R5 back-to-back bursts", last_cyc - first_cyc, 5);
        chk("R9 done after last burst", done_cyc, last_cyc + 1);
        chk("R9 completion word", last_resp, 32'h005A_0000);
        chk("R8 event with done", ev_done, 1);
        chk("R8 no row events", ne, 0);
    endtask

    task automatic t_4d_events();
        launch(mk_flags(3, 2, 0, 0, 0, 0, 8'h03), 4, 2, 2, 2,
               40'h2000, 64'h10, 64'h100, 64'h1000);
        wait_done();
        build_exp(40'h2000, 2, 2, 2, 64'h10, 64'h100, 64'h1000);
        check_rows("R4 4-D walk");
        chk("R8 level-2 event count", ne, 4);
        for (int i = 0; i < 4; i++) chk("R8 level-2 event position", ev_at[i], 2 * (i + 1));
        chk("R8 no completion event", ev_done, 0);
        // wrap of address at its width with a negative stride
        launch(mk_flags(1, 0, 0, 0, 0, 0, 0), 1, 2, 1, 1, 40'h8, -64'h10, 0, 0);
        wait_done();
        chk("R4 address wraps", b_addr[1], 40'hFF_FFFF_FFF8);
    endtask

    task automatic t_fallback();
        launch(mk_flags(0, 1, 0, 0, 0, 0, 0), 64, 5, 5, 5, 40'h300, 64'h40, 0, 0);
        wait_done();
        chk("R2 1-D ignores outer counts", nb, 1);
        chk("R8 fallback event count 1-D", ne, 1);
        chk("R8 fallback event on last burst 1-D", ev_at[0], 1);
        chk("R8 fallback no done event", ev_done, 0);
        launch(mk_flags(1, 3, 0, 0, 0, 0, 0), 2, 3, 9, 9, 40'h0, 64'h20, 0, 0);
        wait_done();
        chk("R2 2-D row count", nb, 3);
        chk("R8 fallback event count 2-D", ne, 1);
        chk("R8 fallback event on last burst 2-D", ev_at[0], 3);
    endtask

    task automatic t_reject();
        launch(mk_flags(0, 0, 0, 0, 0, 0, 8'h11), 0, 1, 1, 1, 40'h0, 0, 0, 0);
        wait_done();
        chk("R3 zero row rejected word", last_resp, 32'h0011_0003);
        chk("R3 zero row no bursts", nb, 0);
        chk("R9 reject done timing", done_cyc, start_cyc + 1);
        chk("R8 no event on reject", ev_done, 0);
        launch(mk_flags(6, 0, 0, 0, 0, 0, 8'h22), 0, 1, 1, 1, 40'h0, 0, 0, 0);
        wait_done();
        chk("R2 R3 unsupported precedence", last_resp, 32'h0022_0004);
        chk("R2 unsupported no bursts", nb, 0);
    endtask

    task automatic t_trig_rows();
        launch(mk_flags(1, 0, 1, 0, 0, 0, 0), 2, 3, 1, 1, 40'h1000, 64'h8, 0, 0);
        repeat (5) @(negedge clk);
        chk("R6 gated before trigger", nb, 0);
        pulse(1);
        chk("R6 unselected input ignored", nb, 0);
        pulse(2);
        chk("R6 unselected local ignored", nb, 0);
        pulse(0);
        chk("R7 one row per level-1 release", nb, 1);
        pulse(0);
        pulse(0);
        wait_done();
        build_exp(40'h1000, 3, 1, 1, 64'h8, 0, 0);
        check_rows("R7 released rows");
        chk("R7 gated record completes", last_resp[3:0], 0);
    endtask

    task automatic t_trig_plane();
        launch(mk_flags(2, 0, 0, 0, 3, 1, 0), 4, 2, 2, 1, 40'h0, 64'h4, 64'h40, 0);
        repeat (3) @(negedge clk);
        pulse(2);
        chk("R7 level-2 release gives one plane", nb, 2);
        chk("R6 trigger1 local select", nd, 0);
        pulse(2);
        wait_done();
        chk("R7 second plane completes", nb, 4);
        launch(mk_flags(1, 0, 2, 2, 0, 0, 0), 4, 3, 1, 1, 40'h0, 64'h4, 0, 0);
        repeat (3) @(negedge clk);
        pulse(1);
        wait_done();
        chk("R7 missing level releases all", nb, 3);
        launch(mk_flags(2, 0, 1, 3, 0, 0, 0), 4, 2, 3, 1, 40'h0, 64'h4, 64'h40, 0);
        repeat (2) @(negedge clk);
        pulse(0);
        wait_done();
        chk("R7 type 3 releases all", nb, 6);
    endtask

    task automatic t_abort();
        launch(mk_flags(1, 0, 2, 0, 0, 0, 8'h44), 4, 4, 1, 1, 40'h0, 64'h4, 0, 0);
        repeat (2) @(negedge clk);
        pulse(1);
        chk("R10 one row before abort", nb, 1);
        pulse(3);
        wait_done();
        chk("R10 aborted word", last_resp, 32'h0044_0002);
        chk("R10 no rows after abort", nb, 1);
        pulse(1);
        chk("R10 trigger after abort ignored", nb, 1);
        clear_mon();
        pulse(3);
        repeat (3) @(negedge clk);
        chk("R10 idle abort no done", nd, 0);
        chk("R10 idle abort busy low", busy, 0);
    endtask

    task automatic t_busy_start();
        launch(mk_flags(1, 0, 1, 3, 0, 0, 8'h01), 3, 2, 1, 1, 40'h500, 64'h10, 0, 0);
        @(negedge clk);
        rec_flags = mk_flags(0, 0, 0, 0, 0, 0, 8'h02);
        rec_addr = 40'h9999;
        rec_icnt0 = 16'd7;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 start while busy ignored", nb, 0);
        pulse(0);
        wait_done();
        build_exp(40'h500, 2, 1, 1, 64'h10, 0, 0);
        check_rows("R1 first record kept");
        chk("R1 first record length", b_len[0], 3);
        chk("R1 first record id", last_resp, 32'h0001_0000);
        chk("R1 single completion", nd, 1);
    endtask

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_free_3d();
        t_4d_events();
        t_fallback();
        t_reject();
        t_trig_rows();
        t_trig_plane();
        t_abort();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule